// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit is the processor-facing side of an interrupt controller. Software uses a small register window to enable the request line, set a priority threshold, take the best pending interrupt and signal that handling is finished. A separate selector supplies the ID of the highest pending interrupt. It also supplies a per-interrupt table of priorities, trigger types, enables and input levels. The unit reports back through one-cycle strobes that clear or set a pending bit.

Taking an interrupt makes it the running one. The unit also records, per interrupt, which interrupt was running before it, so nested handlers form a linked chain. Completing the running interrupt restores its predecessor. Completing an interrupt deeper in the chain removes it from the middle of the chain by walking the links. The walk takes one cycle per link, and while it runs a busy output tells the bus side that accesses are being dropped. A level-triggered, enabled interrupt whose line is still high at completion is pended again.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0 and the mask register (0x04) reads 0xF0. The running-priority register (0x14) reads 0x100, which means no interrupt is running.
- R2: `irq_req` is high exactly when all of these hold: the enable bit is set, the pending ID is below NIRQ and not 1023, its priority is not above the mask, and its priority is strictly below the running priority.
- R3: A read of offset 0x0C returns 1023 and changes nothing when the pending ID is 1023, or when its priority is equal to or above the running priority.
- R4: A successful read of 0x0C returns the pending ID. One cycle later `pend_clr` pulses with that ID. The running priority becomes the priority of that interrupt.
- R5: A write to 0x10 whose low 10 bits equal the running ID restores the interrupt that was running before it. The running priority becomes that interrupt's current priority, or 0x100 if none was running.
- R6: A write to 0x10 naming an interrupt that is deeper in the chain removes it from the chain and leaves the running interrupt and running priority unchanged. Later completions then skip the removed interrupt.
- R7: A write to 0x10 while no interrupt is running has no effect and produces no `pend_set`.
- R8: When a completion is accepted, `pend_set` pulses one cycle later with the written ID. This happens only if that interrupt is level-triggered (`irq_edge` bit 0), enabled and its `irq_level` bit is high.
- R9: Offset 0x18 reads the pending ID. Offset 0x08 always reads 0, and writes to it are ignored. Bit 0 of a write to 0x00 sets the enable, and the low 9 bits of a write to 0x04 set the mask.
- R10: A removal from inside the chain raises `acc_busy` for at most NIRQ cycles. Accesses presented while `acc_busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered at the access edge |
| acc_busy | output | 1 | Chain walk in progress; accesses are dropped |
| pend_id | input | 10 | Highest pending interrupt ID, 1023 if none |
| prio_table | input | NIRQ*PRIO_W | Priority of each interrupt; entry i is at bits i*PRIO_W and up |
| irq_level | input | NIRQ | Current input line level per interrupt |
| irq_edge | input | NIRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_en | input | NIRQ | Per-interrupt enable |
| irq_req | output | 1 | Interrupt request to the processor |
| pend_clr | output | 1 | One-cycle strobe: clear the pending bit of `pend_clr_id` |
| pend_clr_id | output | 10 | ID to clear |
| pend_set | output | 1 | One-cycle strobe: set the pending bit of `pend_set_id` |
| pend_set_id | output | 10 | ID to re-pend |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge. `irq_req` is combinational from the pending inputs and the stored state, so it is checked in the same half-cycle as the stimulus. Read data and both pending strobes are registered at the edge that takes the access, so they are sampled at the falling edge right after that access. `acc_busy` is already high at that sample after an out-of-order completion. The bench then polls it each cycle, with a bound, before making the next access. Any read-back of the running priority is made only after the walk has finished.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
   localparam int ID_W   = 10;
   localparam int REG_AW = 5;
   localparam logic [ID_W-1:0] ID_NONE = '1;

   typedef enum logic [REG_AW-1:0] {
      REG_CTRL  = 5'h00,
      REG_MASK  = 5'h04,
      REG_BPT   = 5'h08,
      REG_ACK   = 5'h0C,
      REG_EOI   = 5'h10,
      REG_RPRI  = 5'h14,
      REG_HPEND = 5'h18
   } reg_off_e;

   typedef enum logic {WALK_IDLE, WALK_RUN} walk_st_e;
endpackage

// File: rtl/irq_link_mem.sv
module irq_link_mem
   import irq_cpu_pkg::*;
#(
   parameter int NIRQ = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [ID_W-1:0] wa,
   input  logic [ID_W-1:0] wd,
   input  logic [ID_W-1:0] ra_a,
   output logic [ID_W-1:0] rd_a,
   input  logic [ID_W-1:0] ra_b,
   output logic [ID_W-1:0] rd_b
);
   localparam int IDX_W = $clog2(NIRQ);
   localparam logic [ID_W-1:0] NIRQ_ID = ID_W'(NIRQ);

   logic [ID_W-1:0] links [NIRQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NIRQ; i++) links[i] <= ID_NONE;
      end else if (we && (wa < NIRQ_ID)) begin
         links[wa[IDX_W-1:0]] <= wd;
      end
   end

   always_comb begin
      rd_a = (ra_a < NIRQ_ID) ? links[ra_a[IDX_W-1:0]] : ID_NONE;
      rd_b = (ra_b < NIRQ_ID) ? links[ra_b[IDX_W-1:0]] : ID_NONE;
   end
endmodule

// File: rtl/irq_chain_walk.sv
module irq_chain_walk
   import irq_cpu_pkg::*;
#(
   parameter int NIRQ = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [ID_W-1:0] start_ptr,
   input  logic [ID_W-1:0] target,
   input  logic [ID_W-1:0] link_at_ptr,
   input  logic [ID_W-1:0] link_of_tgt,
   output logic            busy,
   output logic [ID_W-1:0] ptr,
   output logic [ID_W-1:0] tgt,
   output logic            wr_en,
   output logic [ID_W-1:0] wr_idx,
   output logic [ID_W-1:0] wr_data
);
   localparam int CNT_W = $clog2(NIRQ + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NIRQ - 1);

   walk_st_e        st_q;
   logic [CNT_W-1:0] steps_q;
   logic            hit, at_end;

   assign busy    = (st_q == WALK_RUN);
   assign hit     = busy && (link_at_ptr == tgt) && (link_at_ptr != ID_NONE);
   assign at_end  = (link_at_ptr == ID_NONE) || (steps_q == LAST_STEP);
   assign wr_en   = hit;
   assign wr_idx  = ptr;
   assign wr_data = link_of_tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WALK_IDLE;
         ptr     <= ID_NONE;
         tgt     <= ID_NONE;
         steps_q <= '0;
      end else if (start) begin
         st_q    <= WALK_RUN;
         ptr     <= start_ptr;
         tgt     <= target;
         steps_q <= '0;
      end else if (busy) begin
         if (hit || at_end) begin
            st_q <= WALK_IDLE;
         end else begin
            ptr     <= link_at_ptr;
            steps_q <= steps_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
   import irq_cpu_pkg::*;
#(
   parameter int NIRQ     = 32,
   parameter int PRIO_W   = 8,
   parameter int MASK_RST = 'hF0
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_valid,
   input  logic                   acc_write,
   input  logic [4:0]             acc_addr,
   input  logic [31:0]            acc_wdata,
   output logic [31:0]            acc_rdata,
   output logic                   acc_busy,
   input  logic [9:0]             pend_id,
   input  logic [NIRQ*PRIO_W-1:0] prio_table,
   input  logic [NIRQ-1:0]        irq_level,
   input  logic [NIRQ-1:0]        irq_edge,
   input  logic [NIRQ-1:0]        irq_en,
   output logic                   irq_req,
   output logic                   pend_clr,
   output logic [9:0]             pend_clr_id,
   output logic                   pend_set,
   output logic [9:0]             pend_set_id
);
   localparam int RPRI_W = PRIO_W + 1;
   localparam int IDX_W  = $clog2(NIRQ);
   localparam logic [RPRI_W-1:0] IDLE_PRIO = RPRI_W'(1) << PRIO_W;
   localparam logic [ID_W-1:0]   NIRQ_ID   = ID_W'(NIRQ);

   generate
      if (NIRQ < 2 || NIRQ > 1020) begin : g_bad_nirq
         $error("irq_cpu_if: NIRQ must lie in 2..1020");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("irq_cpu_if: PRIO_W must lie in 1..8");
      end
      if (MASK_RST < 0 || MASK_RST >= (1 << RPRI_W)) begin : g_bad_mask
         $error("irq_cpu_if: MASK_RST does not fit the mask field");
      end
   endgenerate

   logic [PRIO_W-1:0] prio_arr [NIRQ];
   genvar g;
   generate
      for (g = 0; g < NIRQ; g++) begin : g_prio
         assign prio_arr[g] = prio_table[g*PRIO_W +: PRIO_W];
      end
   endgenerate

   function automatic logic [RPRI_W-1:0] lookup_prio(input logic [ID_W-1:0] id);
      if (id < NIRQ_ID) return {1'b0, prio_arr[id[IDX_W-1:0]]};
      return IDLE_PRIO;
   endfunction

   logic              cpu_en_q;
   logic [RPRI_W-1:0] mask_q;
   logic [ID_W-1:0]   run_id_q;
   logic [RPRI_W-1:0] run_prio_q;

   logic            walk_busy, walk_wr, walk_start;
   logic [ID_W-1:0] walk_ptr, walk_tgt, walk_idx, walk_data;
   logic [ID_W-1:0] link_a_idx, link_a, link_b;
   logic            lm_we;
   logic [ID_W-1:0] lm_wa, lm_wd;

   logic              acc_go, rd_go, wr_go;
   logic [RPRI_W-1:0] pend_prio, back_prio;
   logic              pend_valid, ack_ok, do_ack, do_eoi, eoi_hit, repend;
   logic [ID_W-1:0]   eoi_id;
   logic [31:0]       rd_val;

   always_comb begin
      acc_go     = acc_valid && !walk_busy;
      rd_go      = acc_go && !acc_write;
      wr_go      = acc_go && acc_write;
      pend_valid = (pend_id != ID_NONE) && (pend_id < NIRQ_ID);
      pend_prio  = lookup_prio(pend_id);
      ack_ok     = pend_valid && (pend_prio < run_prio_q);
      do_ack     = rd_go && (acc_addr == REG_ACK) && ack_ok;
      eoi_id     = acc_wdata[ID_W-1:0];
      do_eoi     = wr_go && (acc_addr == REG_EOI) && (run_id_q != ID_NONE);
      eoi_hit    = (eoi_id == run_id_q);
      walk_start = do_eoi && !eoi_hit;
      link_a_idx = walk_busy ? walk_ptr : run_id_q;
      back_prio  = lookup_prio(link_a);
      repend     = do_eoi && (eoi_id < NIRQ_ID)
                   && !irq_edge[eoi_id[IDX_W-1:0]]
                   && irq_en[eoi_id[IDX_W-1:0]]
                   && irq_level[eoi_id[IDX_W-1:0]];
      lm_we      = do_ack || walk_wr;
      lm_wa      = do_ack ? pend_id  : walk_idx;
      lm_wd      = do_ack ? run_id_q : walk_data;
      irq_req    = cpu_en_q && pend_valid && (pend_prio <= mask_q)
                   && (pend_prio < run_prio_q);
   end

   always_comb begin
      case (acc_addr)
         REG_CTRL:  rd_val = {31'b0, cpu_en_q};
         REG_MASK:  rd_val = {{(32-RPRI_W){1'b0}}, mask_q};
         REG_ACK:   rd_val = {22'b0, (ack_ok ? pend_id : ID_NONE)};
         REG_RPRI:  rd_val = {{(32-RPRI_W){1'b0}}, run_prio_q};
         REG_HPEND: rd_val = {22'b0, pend_id};
         default:   rd_val = 32'b0;
      endcase
   end

   irq_link_mem #(.NIRQ(NIRQ)) u_links (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (lm_we),
      .wa   (lm_wa),
      .wd   (lm_wd),
      .ra_a (link_a_idx),
      .rd_a (link_a),
      .ra_b (walk_tgt),
      .rd_b (link_b)
   );

   irq_chain_walk #(.NIRQ(NIRQ)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (walk_start),
      .start_ptr  (run_id_q),
      .target     (eoi_id),
      .link_at_ptr(link_a),
      .link_of_tgt(link_b),
      .busy       (walk_busy),
      .ptr        (walk_ptr),
      .tgt        (walk_tgt),
      .wr_en      (walk_wr),
      .wr_idx     (walk_idx),
      .wr_data    (walk_data)
   );

   assign acc_busy = walk_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_en_q    <= 1'b0;
         mask_q      <= RPRI_W'(MASK_RST);
         run_id_q    <= ID_NONE;
         run_prio_q  <= IDLE_PRIO;
         acc_rdata   <= 32'b0;
         pend_clr    <= 1'b0;
         pend_clr_id <= ID_NONE;
         pend_set    <= 1'b0;
         pend_set_id <= ID_NONE;
      end else begin
         pend_clr <= do_ack;
         pend_set <= repend;
         if (rd_go) acc_rdata <= rd_val;
         if (do_ack) begin
            pend_clr_id <= pend_id;
            run_id_q    <= pend_id;
            run_prio_q  <= pend_prio;
         end
         if (repend) pend_set_id <= eoi_id;
         if (do_eoi && eoi_hit) begin
            run_id_q   <= link_a;
            run_prio_q <= back_prio;
         end
         if (wr_go && acc_addr == REG_CTRL) cpu_en_q <= acc_wdata[0];
         if (wr_go && acc_addr == REG_MASK) mask_q   <= acc_wdata[RPRI_W-1:0];
      end
   end
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk #(
   parameter int NIRQ   = 32,
   parameter int RPRI_W = 9
)(
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [4:0]        acc_addr,
   input logic              busy,
   input logic              irq_req,
   input logic              cpu_en,
   input logic [9:0]        pend_id,
   input logic              pend_clr,
   input logic [9:0]        pend_clr_id,
   input logic              pend_set,
   input logic [9:0]        run_id,
   input logic [RPRI_W-1:0] run_prio,
   input logic [RPRI_W-1:0] mask
);
   localparam logic [RPRI_W-1:0] IDLE_P = RPRI_W'(1) << (RPRI_W - 1);

   logic [15:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 16'd1;
      else           busy_len <= '0;
   end

   AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (run_id == 10'd1023) |-> (run_prio == IDLE_P)); // R5

   AST_REQ_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cpu_en && pend_id != 10'd1023)); // R2

   AST_ACK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr |-> (run_id == pend_clr_id)); // R4

   AST_IDLE_EOI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 5'h10 && !busy && run_id == 10'd1023)
      |=> (!pend_set && run_id == 10'd1023)); // R7

   AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(run_id)); // R6

   AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && busy) |=> ($stable(mask) && $stable(cpu_en))); // R10

   AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < 16'(NIRQ))); // R10
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.NIRQ(NIRQ), .RPRI_W(PRIO_W + 1)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_addr   (acc_addr),
   .busy       (acc_busy),
   .irq_req    (irq_req),
   .cpu_en     (cpu_en_q),
   .pend_id    (pend_id),
   .pend_clr   (pend_clr),
   .pend_clr_id(pend_clr_id),
   .pend_set   (pend_set),
   .run_id     (run_id_q),
   .run_prio   (run_prio_q),
   .mask       (mask_q)
);

// File: tb/test_irq_cpu_if.sv
module test_irq_cpu_if;
   localparam int NIRQ = 32;
   localparam int PW   = 8;
   localparam logic [9:0] NONE = 10'd1023;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [4:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        acc_busy;
   logic [9:0]  pend_id = NONE;
   logic [NIRQ*PW-1:0] prio_table = '1;
   logic [NIRQ-1:0] irq_level = '0, irq_edge = '0, irq_en = '0;
   logic irq_req, pend_clr, pend_set;
   logic [9:0] pend_clr_id, pend_set_id;

   int checks = 0, fails = 0;
   logic [31:0] g_rd;
   logic g_clr, g_set;
   logic [9:0] g_clr_id, g_set_id;

   // bench model of the running chain
   logic [9:0] m_link [NIRQ];
   logic [9:0] m_run = NONE;
   logic [8:0] m_rp  = 9'h100;
   logic       m_en  = 1'b0;
   logic [8:0] m_mask = 9'h0F0;

   always #10 clk = ~clk;

   irq_cpu_if i_irq_cpu_if (.*);

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] bprio(input logic [9:0] id);
      if (id < NIRQ) return {1'b0, prio_table[id*PW +: PW]};
      return 9'h100;
   endfunction

   function automatic logic exp_req();
      logic [8:0] p = bprio(pend_id);
      return m_en && pend_id != NONE && pend_id < NIRQ && p <= m_mask && p < m_rp;
   endfunction

   task automatic acc_raw(input logic wr, input logic [4:0] a, input logic [31:0] d);
      acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
      @(posedge clk); @(negedge clk);
      acc_valid = 1'b0;
      g_rd = acc_rdata; g_clr = pend_clr; g_clr_id = pend_clr_id;
      g_set = pend_set; g_set_id = pend_set_id;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (acc_busy && cyc < NIRQ + 4) begin
         @(negedge clk); cyc++;
      end
   endtask

   task automatic acc(input logic wr, input logic [4:0] a, input logic [31:0] d);
      int cyc;
      acc_raw(wr, a, d);
      wait_idle(cyc);
   endtask

   task automatic set_prio(input int id, input logic [7:0] p);
      prio_table[id*PW +: PW] = p;
   endtask

   // model of acknowledge; returns expected read value
   function automatic logic [9:0] m_ack();
      if (pend_id != NONE && pend_id < NIRQ && bprio(pend_id) < m_rp) begin
         m_link[pend_id[4:0]] = m_run;
         m_run = pend_id;
         m_rp  = bprio(pend_id);
         return pend_id;
      end
      return NONE;
   endfunction

   // model of completion; returns whether a re-pend is expected
   function automatic logic m_eoi(input logic [9:0] id);
      logic rp;
      logic [9:0] tmp;
      if (m_run == NONE) return 1'b0;
      rp = id < NIRQ && !irq_edge[id[4:0]] && irq_en[id[4:0]] && irq_level[id[4:0]];
      if (id == m_run) begin
         m_run = m_link[m_run[4:0]];
         m_rp  = bprio(m_run);
      end else begin
         tmp = m_run;
         for (int s = 0; s < NIRQ; s++) begin
            if (m_link[tmp[4:0]] == NONE) break;
            if (m_link[tmp[4:0]] == id) begin
               m_link[tmp[4:0]] = (id < NIRQ) ? m_link[id[4:0]] : NONE;
               break;
            end
            tmp = m_link[tmp[4:0]];
         end
      end
      return rp;
   endfunction

   task automatic do_ack_chk(input string req);
      logic [9:0] e;
      e = m_ack();
      acc(1'b0, 5'h0C, 0);
      chk({req, " ack value"}, g_rd, {22'b0, e});
      chk({req, " clear strobe"}, {g_clr, (g_clr ? g_clr_id : NONE)},
          {e != NONE, e});
   endtask

   task automatic do_eoi_chk(input string req, input logic [9:0] id);
      logic e;
      e = m_eoi(id);
      acc(1'b1, 5'h10, {22'b0, id});
      chk({req, " repend strobe"}, {g_set, (g_set ? g_set_id : NONE)},
          {e, (e ? id : NONE)});
   endtask

   task automatic rpri_chk(input string req);
      acc(1'b0, 5'h14, 0);
      chk({req, " running prio"}, g_rd, {23'b0, m_rp});
   endtask

   initial begin
      int cyc;
      void'($urandom(32'd24601));
      for (int i = 0; i < NIRQ; i++) m_link[i] = NONE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      acc(1'b0, 5'h00, 0); chk("R1 ctrl", g_rd, 0);
      acc(1'b0, 5'h04, 0); chk("R1 mask", g_rd, 32'hF0);
      acc(1'b0, 5'h14, 0); chk("R1 running prio", g_rd, 32'h100);
      // R9 / R3 empty pending
      acc(1'b0, 5'h18, 0); chk("R9 pending readback", g_rd, 32'd1023);
      do_ack_chk("R3 nothing pending");
      // R7 completion when idle
      irq_en[5] = 1'b1; irq_level[5] = 1'b1;
      do_eoi_chk("R7 idle completion", 10'd5);
      rpri_chk("R7");
      // R9 binary point
      acc(1'b1, 5'h08, 32'hFF); acc(1'b0, 5'h08, 0); chk("R9 binary point", g_rd, 0);
      acc(1'b1, 5'h00, 1); m_en = 1'b1;
      acc(1'b0, 5'h00, 0); chk("R9 enable readback", g_rd, 1);

      set_prio(3, 8'h80); set_prio(7, 8'h40); set_prio(9, 8'h20);
      set_prio(12, 8'h10); set_prio(20, 8'hF8);
      pend_id = 10'd20; #1; chk("R2 masked request", irq_req, 0);
      pend_id = 10'd3;  #1; chk("R2 request raised", irq_req, 1);
      do_ack_chk("R4 take 3");
      rpri_chk("R4");
      chk("R2 request dropped", irq_req, 0);
      do_ack_chk("R3 equal priority");
      pend_id = 10'd7;  do_ack_chk("R4 take 7");
      pend_id = 10'd9;  do_ack_chk("R4 take 9");
      pend_id = 10'd12; do_ack_chk("R4 take 12");
      rpri_chk("R4 nested");
      pend_id = NONE;

      // R10 busy walk, R6 out-of-order completion of 3
      void'(m_eoi(10'd3));
      acc_raw(1'b1, 5'h10, 32'd3);
      chk("R10 busy after removal", acc_busy, 1);
      acc_raw(1'b1, 5'h04, 32'h33);
      wait_idle(cyc);
      chk("R10 walk bounded", acc_busy, 0);
      acc(1'b0, 5'h04, 0); chk("R10 access dropped while busy", g_rd, 32'hF0);
      rpri_chk("R6 running kept");

      // R8 / R5 unwind
      irq_en[12] = 1'b1; irq_level[12] = 1'b1; irq_edge[12] = 1'b0;
      do_eoi_chk("R8 level repend", 10'd12);
      rpri_chk("R5 back to 9");
      irq_en[9] = 1'b1; irq_level[9] = 1'b1; irq_edge[9] = 1'b1;
      do_eoi_chk("R8 edge no repend", 10'd9);
      rpri_chk("R5 back to 7");
      do_eoi_chk("R6 removed entry skipped", 10'd7);
      rpri_chk("R5 idle again");
      do_eoi_chk("R7 second idle completion", 10'd7);

      // constrained random phase
      for (int i = 0; i < NIRQ; i++) set_prio(i, 8'($urandom_range(0, 255)));
      for (int it = 0; it < 400; it++) begin
         irq_level = $urandom; irq_edge = $urandom; irq_en = $urandom;
         if ($urandom_range(0, 9) == 0) begin
            m_mask = 9'($urandom_range(0, 511));
            acc(1'b1, 5'h04, {23'b0, m_mask});
            m_en = 1'($urandom_range(0, 3) != 0);
            acc(1'b1, 5'h00, {31'b0, m_en});
         end
         pend_id = ($urandom_range(0, 7) == 0) ? NONE : 10'($urandom_range(0, NIRQ - 1));
         #1; chk("R2 random request", irq_req, exp_req());
         if ($urandom_range(0, 1) == 0) begin
            do_ack_chk("R4 random ack");
         end else if (m_run != NONE && $urandom_range(0, 1) == 0) begin
            do_eoi_chk("R5 random complete running", m_run);
         end else begin
            do_eoi_chk("R6 random complete any", 10'($urandom_range(0, NIRQ - 1)));
         end
         rpri_chk("R5 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule